// File: doc/BRIEF.md
# Refresh Scheduler with Postponement

This block decides when a DDR SDRAM controller owes the memory a refresh. A free-running interval timer, set in controller clock cycles, adds one unit of refresh debt each time it expires. While any debt is outstanding, the block raises a request to the command arbiter. The arbiter may postpone that request to finish useful traffic, and it pays one unit back with each grant. The device refreshes rows from an internal address counter, so the block drives no address. One command covers exactly one unit of debt.

The arbiter may defer refreshes until eight are owed. At that point the block raises an urgent request, and the arbiter must serve it before it starts any other command. Under that rule, no two granted refreshes are ever more than nine intervals apart. After each accepted grant, a busy flag stays high for the refresh cycle time (tRFC). During that window the controller keeps clock enable high and issues nothing to the device. The block presents no request while busy is high. The parameters must satisfy INTERVAL_CYC > TRFC_CYC.

Top module: `refsched_top`

## Requirements
- R1: While reset is high and on the first cycle after it, owed_cnt is 0 and ref_req, ref_urgent and ref_busy are low. The interval timer restarts from zero.
- R2: Without grants, owed_cnt rises by one every INTERVAL_CYC cycles. The first rise is visible INTERVAL_CYC clock edges after reset is released.
- R3: ref_req is high exactly when owed_cnt is nonzero and ref_busy is low.
- R4: A grant is accepted only in a cycle where ref_gnt and ref_req are both high, and it lowers owed_cnt by one. A ref_gnt while ref_req is low has no effect on owed_cnt or ref_busy.
- R5: When the timer expires in the same cycle that a grant is accepted, owed_cnt is unchanged.
- R6: ref_urgent is high exactly when owed_cnt equals MAX_OWED (8) and ref_busy is low.
- R7: After an accepted grant, ref_busy is high for exactly TRFC_CYC cycles, starting the next cycle, and ref_req stays low during that window.
- R8: owed_cnt never exceeds MAX_OWED. If the arbiter grants every urgent request, no two accepted grants are more than 9 × INTERVAL_CYC cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | Arbiter grant, taken when ref_req is high |
| ref_req | output | 1 | Refresh requested |
| ref_urgent | output | 1 | Debt at limit; must be granted before any other command |
| ref_busy | output | 1 | Refresh cycle time in progress |
| owed_cnt | output | 4 | Number of refreshes currently owed |

## Verification
Timer expiry and an accepted grant can fall in the same edge, and then the debt must hold its value. A directed phase forces that overlap: the bench grants only in cycles where its model shows the timer at its last count. A random phase also produces the overlap at random. A bench model steps the timer, debt and busy window from the requirements, and the outputs are compared to it every cycle. Separate phases cover grants that arrive while no request is up and grants held back until the urgent request. Throughout, the bench checks the gap between grants against the nine-interval bound.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

    typedef enum logic [1:0] {
        DEBT_HOLD = 2'd0,
        DEBT_UP   = 2'd1,
        DEBT_DOWN = 2'd2
    } debt_op_e;

    typedef struct packed {
        logic req;
        logic urgent;
        logic busy;
    } ref_status_t;

    function automatic int unsigned cnt_width(int unsigned maxval);
        return (maxval < 2) ? 1 : $clog2(maxval + 1);
    endfunction

    function automatic debt_op_e pick_op(logic expire, logic take);
        if (expire && !take) return DEBT_UP;
        if (take && !expire) return DEBT_DOWN;
        return DEBT_HOLD;
    endfunction

endpackage

// File: rtl/refsched_interval_timer.sv
module refsched_interval_timer
    import refsched_pkg::*;
#(
    parameter int unsigned INTERVAL_CYC = 1560
) (
    input  logic clk,
    input  logic rst,
    output logic expire
);
    localparam int unsigned TW = cnt_width(INTERVAL_CYC - 1);
    localparam logic [TW-1:0] LAST = TW'(INTERVAL_CYC - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign expire = (cnt == LAST);

    // R2
    expire_single_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> !expire);

endmodule

// File: rtl/refsched_debt_counter.sv
module refsched_debt_counter
    import refsched_pkg::*;
#(
    parameter int unsigned MAX_OWED = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic take,
    output logic [cnt_width(MAX_OWED)-1:0] debt,
    output logic at_max
);
    localparam int unsigned DW = cnt_width(MAX_OWED);
    localparam logic [DW-1:0] LIMIT = DW'(MAX_OWED);

    debt_op_e op;
    assign op = pick_op(expire, take);

    always_ff @(posedge clk) begin
        if (rst) begin
            debt <= '0;
        end else begin
            case (op)
                DEBT_UP:   if (debt != LIMIT) debt <= debt + 1'b1;
                DEBT_DOWN: if (debt != '0)    debt <= debt - 1'b1;
                default:   debt <= debt;
            endcase
        end
    end

    assign at_max = (debt == LIMIT);

    // R8
    debt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        debt <= LIMIT);

    // R5
    tick_take_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (expire && take) |=> $stable(debt));

    // R4
    take_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !expire && debt != '0) |=> (debt == $past(debt) - 1'b1));

endmodule

// File: rtl/refsched_busy_window.sv
module refsched_busy_window
    import refsched_pkg::*;
#(
    parameter int unsigned TRFC_CYC = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic take,
    output logic busy
);
    localparam int unsigned BW = cnt_width(TRFC_CYC);
    localparam logic [BW-1:0] LOADV = BW'(TRFC_CYC);

    logic [BW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)                remain <= '0;
        else if (take)          remain <= LOADV;
        else if (remain != '0)  remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);

    // R7
    busy_set_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> busy);

endmodule

// File: rtl/refsched_top.sv
module refsched_top
    import refsched_pkg::*;
#(
    parameter int unsigned INTERVAL_CYC = 1560,
    parameter int unsigned TRFC_CYC     = 15,
    parameter int unsigned MAX_OWED     = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_gnt,
    output logic ref_req,
    output logic ref_urgent,
    output logic ref_busy,
    output logic [cnt_width(MAX_OWED)-1:0] owed_cnt
);
    localparam int unsigned DW = cnt_width(MAX_OWED);

    logic expire;
    logic take;
    logic at_max;
    logic [DW-1:0] debt;
    logic busy;
    ref_status_t st;

    refsched_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .expire (expire)
    );

    refsched_debt_counter #(.MAX_OWED(MAX_OWED)) u_debt (
        .clk    (clk),
        .rst    (rst),
        .expire (expire),
        .take   (take),
        .debt   (debt),
        .at_max (at_max)
    );

    refsched_busy_window #(.TRFC_CYC(TRFC_CYC)) u_busy (
        .clk  (clk),
        .rst  (rst),
        .take (take),
        .busy (busy)
    );

    always_comb begin
        st.busy   = busy;
        st.req    = (debt != '0) && !busy;
        st.urgent = at_max && !busy;
    end

    assign take       = ref_gnt && st.req;
    assign ref_req    = st.req;
    assign ref_urgent = st.urgent;
    assign ref_busy   = st.busy;
    assign owed_cnt   = debt;

    // R7
    busy_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        ref_busy |-> !ref_req);

    // R6
    urgent_has_req_chk: assert property (@(posedge clk) disable iff (rst)
        ref_urgent |-> ref_req);

    // R4
    ignored_gnt_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_gnt && !ref_req && !ref_busy) |=> !ref_busy);

endmodule

// File: tb/refsched_top_tb.sv
`timescale 1ns/1ps
module refsched_top_tb;
    localparam int INT_C  = 40;
    localparam int TRFC_C = 6;
    localparam int MAXO   = 8;
    localparam int GAP_LIM = 9 * INT_C;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic gnt = 1'b0;
    logic req, urg, busy;
    logic [3:0] owed;

    always #2.5 clk = ~clk;

    refsched_top #(.INTERVAL_CYC(INT_C), .TRFC_CYC(TRFC_C), .MAX_OWED(MAXO)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .ref_gnt    (gnt),
        .ref_req    (req),
        .ref_urgent (urg),
        .ref_busy   (busy),
        .owed_cnt   (owed)
    );

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;
    int m_t = 0, m_d = 0, m_b = 0, gap = 0;
    int seen_urgent = 0, seen_overlap = 0;
    string phase = "R1";
    bit tk, tak;

    function automatic bit exp_req(int d, int b);
        return (d != 0) && (b == 0);
    endfunction

    function automatic bit exp_urg(int d, int b);
        return (d == MAXO) && (b == 0);
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    // reference model stepped on every edge
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL R8 watchdog: cycles %0d expected below %0d", cyc, 150000);
            finish_run();
        end
        if (rst) begin
            m_t = 0; m_d = 0; m_b = 0; gap = 0;
        end else begin
            tk  = (m_t == INT_C - 1);
            tak = gnt && exp_req(m_d, m_b);
            if (tk && tak) seen_overlap++;
            if (tak) begin
                vectors++;
                if (gap + 1 > GAP_LIM) begin
                    fails++;
                    $display("FAIL R8 grant gap: actual %0d expected <= %0d", gap + 1, GAP_LIM);
                end
                gap = 0;
            end else begin
                gap++;
                if (gap == GAP_LIM + 1) begin
                    vectors++; fails++;
                    $display("FAIL R8 no grant: actual gap %0d expected <= %0d", gap, GAP_LIM);
                end
            end
            m_t = tk ? 0 : m_t + 1;
            if (tk && !tak)      m_d = (m_d < MAXO) ? m_d + 1 : m_d;
            else if (!tk && tak) m_d = m_d - 1;
            m_b = tak ? TRFC_C : ((m_b > 0) ? m_b - 1 : 0);
        end
    end

    // output comparison away from the active edge
    always @(negedge clk) begin
        vectors++;
        if (owed !== 4'(m_d)) begin
            fails++;
            $display("FAIL R2/%s owed_cnt: actual %0d expected %0d", phase, owed, m_d);
        end
        if (req !== exp_req(m_d, m_b)) begin
            fails++;
            $display("FAIL R3/%s ref_req: actual %0b expected %0b", phase, req, exp_req(m_d, m_b));
        end
        if (urg !== exp_urg(m_d, m_b)) begin
            fails++;
            $display("FAIL R6/%s ref_urgent: actual %0b expected %0b", phase, urg, exp_urg(m_d, m_b));
        end
        if (busy !== (m_b != 0)) begin
            fails++;
            $display("FAIL R7/%s ref_busy: actual %0b expected %0b", phase, busy, m_b != 0);
        end
        if (owed > 4'(MAXO)) begin
            fails++;
            $display("FAIL R8 owed bound: actual %0d expected <= %0d", owed, MAXO);
        end
        if (urg === 1'b1) seen_urgent++;
    end

    // mode: 0 none, 1 urgent only, 2 only while no request, 3 on timer expiry, 4 random
    function automatic bit pick_gnt(int mode);
        bit r = exp_req(m_d, m_b);
        if (exp_urg(m_d, m_b)) return 1'b1;
        case (mode)
            1: return 1'b0;
            2: return !r;
            3: return r && (m_t == INT_C - 1);
            4: return ($urandom % 4) == 0;
            default: return 1'b0;
        endcase
    endfunction

    task automatic run_phase(string tag, int mode, int ncyc);
        phase = tag;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            #0.5 gnt = pick_gnt(mode);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED));
        // R1: reset state, with a stray grant that must not matter
        gnt = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #0.5 gnt = 1'b0;
        rst = 1'b0;
        run_phase("R2", 0, 2 * INT_C + 5);
        run_phase("R6", 1, 12 * INT_C);
        run_phase("R4", 2, 3 * INT_C);
        run_phase("R5", 3, 10 * INT_C);
        run_phase("R8", 4, 15000);
        run_phase("R7", 4, 200);
        @(negedge clk);
        vectors++;
        if (seen_urgent == 0) begin
            fails++;
            $display("FAIL R6 urgent never raised: actual %0d expected > 0", seen_urgent);
        end
        vectors++;
        if (seen_overlap == 0) begin
            fails++;
            $display("FAIL R5 no expiry/grant overlap: actual %0d expected > 0", seen_overlap);
        end
        finish_run();
    end

endmodule